// File: doc/BRIEF.md
# Receive Header and Payload Depositor

This block sits behind the line decoder of a serial link and receives one symbol per clock. Each symbol is a byte plus a flag that marks it as a control symbol. A new-header control symbol opens a packet. The bytes after it are header bytes. A payload control symbol switches the packet to payload, and the bytes after it are payload bytes. Neither control symbol is written to memory.

Payload bytes stream without gaps into a payload ring. Header bytes go into a separate header ring, where every packet becomes one self-describing entry:
- a 16-bit length that the hardware writes in front of the header;
- the header bytes;
- padding up to an 8-byte boundary;
- an 8-byte trailer holding the 48-bit payload address and the 16-bit payload size.

With the length and trailer in place, software can step from entry to entry without looking at any payload. Both rings are a power of two in size, and their write cursors wrap by masking. Both write cursors are published as outputs, so software can read them at any time. Each ring is modelled as write lanes. The header ring has three lanes: a byte lane, a 16-bit length lane and a 64-bit trailer lane.

Top module: `rxd_depositor`

## Requirements
- R1: A symbol with the control flag set and data 8'hF1 opens a header, and one with data 8'hF2 opens the payload of an open header. No control symbol is ever written to memory. Other control codes, data bytes received before the first header, and a payload symbol received while no header is open are ignored.
- R2: Header byte i of an entry whose base is B is written on the byte lane at ring offset B+2+i. The write appears one clock after the byte is received.
- R3: The header length L is written little-endian at offset B on the length lane. It is written only when the payload symbol or the next header symbol ends the header, and it counts header bytes only.
- R4: The trailer is written on the trailer lane as one 8-byte word at B plus (L+2) rounded up to a multiple of 8. Bytes 0 to 5 hold the payload address, which is PAY_BASE plus the payload-ring offset of the packet's first payload byte. Bytes 6 and 7 hold the payload size. Both fields are little-endian.
- R5: Payload bytes are written one per received byte at consecutive payload-ring offsets, wrapping modulo the ring size.
- R6: The header cursor equals the base of the entry being filled. It changes only in the clock after a header symbol closes a packet, and it then advances past the whole entry (trailer offset + 8) in a single step.
- R7: The payload cursor is the offset of the next payload write and advances by one per payload byte.
- R8: A header longer than 128 bytes raises hdr_err for one clock on its 129th byte. That entry is then discarded: no length or trailer is written and the header cursor does not move. Its payload bytes are still written to the payload ring.
- R9: Header ring offsets, including the trailer position, wrap modulo the header ring size.
- R10: A packet that carries no payload bytes gets payload size 0 and the address of the next payload byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sym_valid | input | 1 | A symbol is present this clock |
| sym_ctrl | input | 1 | The symbol is a control symbol |
| sym_data | input | 8 | Symbol byte or control code |
| hb_we | output | 1 | Header byte lane write |
| hb_addr | output | HAW | Header byte lane offset |
| hb_data | output | 8 | Header byte |
| hl_we | output | 1 | Length lane write |
| hl_addr | output | HAW | Length lane offset (entry base) |
| hl_data | output | 16 | Header length |
| tr_we | output | 1 | Trailer lane write |
| tr_addr | output | HAW | Trailer offset, 8-byte aligned |
| tr_data | output | 64 | {size[15:0], address[47:0]} |
| pay_we | output | 1 | Payload ring write |
| pay_addr | output | PAW | Payload ring offset |
| pay_data | output | 8 | Payload byte |
| hdr_cursor | output | HAW | Header ring write cursor |
| pay_cursor | output | PAW | Payload ring write cursor |
| hdr_err | output | 1 | Over-length header pulse |

## Verification
The hardest cases to reach are an entry whose bytes and trailer straddle the end of the header ring, and an over-length header whose payload must still land in the payload ring while the header entry disappears.

The stimulus walks a table of packet shapes twice. The shapes include 127- and 128-byte headers, empty headers and packets without payload, so both rings wrap in the middle of entries. After the table, a 130-byte header is sent with a short payload. The packet that follows it is then checked at the very same base, which shows that the discarded entry moved nothing.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam logic [7:0] SYM_NEWHDR  = 8'hF1;
  localparam logic [7:0] SYM_PAYLOAD = 8'hF2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HEAD = 2'd1,
    ST_BODY = 2'd2
  } rx_state_e;
endpackage

// File: rtl/rxd_framer.sv
module rxd_framer
  import rxd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_valid,
  input  logic       sym_ctrl,
  input  logic [7:0] sym_data,
  output rx_state_e  state_o,
  output logic       ev_hdr,
  output logic       ev_pay,
  output logic       ev_hbyte,
  output logic       ev_pbyte
);
  rx_state_e state_q, state_d;

  always_comb begin
    ev_hdr   = sym_valid && sym_ctrl && (sym_data == SYM_NEWHDR);
    ev_pay   = sym_valid && sym_ctrl && (sym_data == SYM_PAYLOAD) && (state_q == ST_HEAD);
    ev_hbyte = sym_valid && !sym_ctrl && (state_q == ST_HEAD);
    ev_pbyte = sym_valid && !sym_ctrl && (state_q == ST_BODY);
    state_d  = state_q;
    if (ev_hdr)      state_d = ST_HEAD;
    else if (ev_pay) state_d = ST_BODY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // R1
  body_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BODY && $past(state_q) != ST_BODY) |-> $past(ev_pay));
endmodule

// File: rtl/rxd_pay_writer.sv
module rxd_pay_writer #(
  parameter int PAW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ev_pay,
  input  logic           ev_pbyte,
  input  logic [7:0]     byte_i,
  output logic           pay_we,
  output logic [PAW-1:0] pay_addr,
  output logic [7:0]     pay_data,
  output logic [PAW-1:0] cur_o,
  output logic [PAW-1:0] start_o,
  output logic [15:0]    size_o
);
  logic [PAW-1:0] cur_q, cur_d, start_q, start_d, addr_q;
  logic [15:0]    size_q, size_d;
  logic [7:0]     data_q;
  logic           we_q;

  always_comb begin
    cur_d   = cur_q;
    start_d = start_q;
    size_d  = size_q;
    if (ev_pay) begin
      start_d = cur_q;
      size_d  = '0;
    end
    if (ev_pbyte) begin
      cur_d  = cur_q + 1'b1;
      size_d = size_q + 16'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      start_q <= '0;
      size_q  <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      cur_q   <= cur_d;
      start_q <= start_d;
      size_q  <= size_d;
      we_q    <= ev_pbyte;
      if (ev_pbyte) begin
        addr_q <= cur_q;
        data_q <= byte_i;
      end
    end
  end

  assign pay_we   = we_q;
  assign pay_addr = addr_q;
  assign pay_data = data_q;
  assign cur_o    = cur_q;
  assign start_o  = start_q;
  assign size_o   = size_q;

  // R7
  pay_cursor_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pay_we |-> (pay_addr == PAW'(cur_q - 1'b1)));
  // R5
  pay_cursor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q != $past(cur_q)) |-> pay_we);
endmodule

// File: rtl/rxd_hdr_writer.sv
module rxd_hdr_writer
  import rxd_pkg::*;
#(
  parameter int          HAW      = 10,
  parameter int          PAW      = 8,
  parameter int          MAXH     = 128,
  parameter logic [47:0] PAY_BASE = 48'h0000_4000_0000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  rx_state_e      state_i,
  input  logic           ev_hdr,
  input  logic           ev_pay,
  input  logic           ev_hbyte,
  input  logic [7:0]     byte_i,
  input  logic [PAW-1:0] pay_cur,
  input  logic [PAW-1:0] pay_start,
  input  logic [15:0]    pay_size,
  output logic           hb_we,
  output logic [HAW-1:0] hb_addr,
  output logic [7:0]     hb_data,
  output logic           hl_we,
  output logic [HAW-1:0] hl_addr,
  output logic [15:0]    hl_data,
  output logic           tr_we,
  output logic [HAW-1:0] tr_addr,
  output logic [63:0]    tr_data,
  output logic           err_o,
  output logic [HAW-1:0] cursor_o
);
  localparam int CW = $clog2(MAXH + 1);

  logic [CW-1:0]  cnt_q, cnt_d;
  logic           ovf_q, ovf_d, err_q, err_d;
  logic [HAW-1:0] base_q, base_d, tro;
  logic           hb_we_q, hb_we_d, hl_we_q, hl_we_d, tr_we_q, tr_we_d;
  logic [HAW-1:0] hb_addr_q, hb_addr_d, hl_addr_q, hl_addr_d, tr_addr_q, tr_addr_d;
  logic [7:0]     hb_data_q;
  logic [15:0]    hl_data_q, hl_data_d;
  logic [63:0]    tr_data_q, tr_data_d;
  logic [47:0]    pl;
  logic [15:0]    ps;

  always_comb begin
    tro = (HAW'(cnt_q) + HAW'(9)) & ~HAW'(7);
    if (state_i == ST_BODY) begin
      pl = PAY_BASE + 48'(pay_start);
      ps = pay_size;
    end else begin
      pl = PAY_BASE + 48'(pay_cur);
      ps = '0;
    end
    cnt_d     = cnt_q;
    ovf_d     = ovf_q;
    base_d    = base_q;
    err_d     = 1'b0;
    hb_we_d   = 1'b0;
    hl_we_d   = 1'b0;
    tr_we_d   = 1'b0;
    hb_addr_d = base_q + HAW'(2) + HAW'(cnt_q);
    hl_addr_d = base_q;
    hl_data_d = 16'(cnt_q);
    tr_addr_d = base_q + tro;
    tr_data_d = {ps, pl};
    if (ev_hbyte) begin
      if (cnt_q < CW'(MAXH)) begin
        hb_we_d = 1'b1;
        cnt_d   = cnt_q + 1'b1;
      end else begin
        ovf_d = 1'b1;
        err_d = !ovf_q;
      end
    end
    if (ev_pay && !ovf_q) hl_we_d = 1'b1;
    if (ev_hdr) begin
      if (state_i != ST_IDLE && !ovf_q) begin
        tr_we_d = 1'b1;
        hl_we_d = (state_i == ST_HEAD);
        base_d  = base_q + tro + HAW'(8);
      end
      cnt_d = '0;
      ovf_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      ovf_q     <= 1'b0;
      err_q     <= 1'b0;
      base_q    <= '0;
      hb_we_q   <= 1'b0;
      hl_we_q   <= 1'b0;
      tr_we_q   <= 1'b0;
      hb_addr_q <= '0;
      hb_data_q <= '0;
      hl_addr_q <= '0;
      hl_data_q <= '0;
      tr_addr_q <= '0;
      tr_data_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      ovf_q   <= ovf_d;
      err_q   <= err_d;
      base_q  <= base_d;
      hb_we_q <= hb_we_d;
      hl_we_q <= hl_we_d;
      tr_we_q <= tr_we_d;
      if (hb_we_d) begin
        hb_addr_q <= hb_addr_d;
        hb_data_q <= byte_i;
      end
      if (hl_we_d) begin
        hl_addr_q <= hl_addr_d;
        hl_data_q <= hl_data_d;
      end
      if (tr_we_d) begin
        tr_addr_q <= tr_addr_d;
        tr_data_q <= tr_data_d;
      end
    end
  end

  assign hb_we    = hb_we_q;
  assign hb_addr  = hb_addr_q;
  assign hb_data  = hb_data_q;
  assign hl_we    = hl_we_q;
  assign hl_addr  = hl_addr_q;
  assign hl_data  = hl_data_q;
  assign tr_we    = tr_we_q;
  assign tr_addr  = tr_addr_q;
  assign tr_data  = tr_data_q;
  assign err_o    = err_q;
  assign cursor_o = base_q;

  logic [HAW-1:0] hb_rel;
  assign hb_rel = hb_addr_q - base_q;

  // R2
  hdr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hb_we |-> (hb_rel >= HAW'(2) && hb_rel <= HAW'(MAXH + 1)));
  // R3
  len_on_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hl_we |-> $past(ev_hdr || ev_pay));
  // R4
  trailer_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tr_we |-> (tr_addr[2:0] == 3'd0));
  // R6
  cursor_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cursor_o != $past(cursor_o)) |-> tr_we);
  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);
endmodule

// File: rtl/rxd_depositor.sv
module rxd_depositor
  import rxd_pkg::*;
#(
  parameter int          HAW      = 10,
  parameter int          PAW      = 8,
  parameter int          MAXH     = 128,
  parameter logic [47:0] PAY_BASE = 48'h0000_4000_0000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sym_valid,
  input  logic           sym_ctrl,
  input  logic [7:0]     sym_data,
  output logic           hb_we,
  output logic [HAW-1:0] hb_addr,
  output logic [7:0]     hb_data,
  output logic           hl_we,
  output logic [HAW-1:0] hl_addr,
  output logic [15:0]    hl_data,
  output logic           tr_we,
  output logic [HAW-1:0] tr_addr,
  output logic [63:0]    tr_data,
  output logic           pay_we,
  output logic [PAW-1:0] pay_addr,
  output logic [7:0]     pay_data,
  output logic [HAW-1:0] hdr_cursor,
  output logic [PAW-1:0] pay_cursor,
  output logic           hdr_err
);
  logic [1:0] rs_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  rx_state_e      state;
  logic           ev_hdr, ev_pay, ev_hbyte, ev_pbyte;
  logic [PAW-1:0] p_start;
  logic [15:0]    p_size;

  rxd_framer u_framer (
    .clk(clk), .rst_n(rst_n_s), .sym_valid(sym_valid), .sym_ctrl(sym_ctrl),
    .sym_data(sym_data), .state_o(state), .ev_hdr(ev_hdr), .ev_pay(ev_pay),
    .ev_hbyte(ev_hbyte), .ev_pbyte(ev_pbyte)
  );

  rxd_pay_writer #(.PAW(PAW)) u_pay (
    .clk(clk), .rst_n(rst_n_s), .ev_pay(ev_pay), .ev_pbyte(ev_pbyte),
    .byte_i(sym_data), .pay_we(pay_we), .pay_addr(pay_addr), .pay_data(pay_data),
    .cur_o(pay_cursor), .start_o(p_start), .size_o(p_size)
  );

  rxd_hdr_writer #(.HAW(HAW), .PAW(PAW), .MAXH(MAXH), .PAY_BASE(PAY_BASE)) u_hdr (
    .clk(clk), .rst_n(rst_n_s), .state_i(state), .ev_hdr(ev_hdr), .ev_pay(ev_pay),
    .ev_hbyte(ev_hbyte), .byte_i(sym_data), .pay_cur(pay_cursor),
    .pay_start(p_start), .pay_size(p_size),
    .hb_we(hb_we), .hb_addr(hb_addr), .hb_data(hb_data),
    .hl_we(hl_we), .hl_addr(hl_addr), .hl_data(hl_data),
    .tr_we(tr_we), .tr_addr(tr_addr), .tr_data(tr_data),
    .err_o(hdr_err), .cursor_o(hdr_cursor)
  );
endmodule

// File: tb/tb_rxd_depositor.sv
`timescale 1ns/1ps
module tb_rxd_depositor;
  localparam int          HAW      = 10;
  localparam int          PAW      = 8;
  localparam int          HSZ      = 1 << HAW;
  localparam int          PSZ      = 1 << PAW;
  localparam logic [47:0] PAY_BASE = 48'h0000_4000_0000;
  localparam logic [7:0]  NEWHDR   = 8'hF1;
  localparam logic [7:0]  PAYSYM   = 8'hF2;
  localparam int          NV       = 8;
  // {header length, payload length, payload symbol sent}
  localparam logic [16:0] VEC [NV] = '{
    {8'd8,   8'd20, 1'b1}, {8'd0,   8'd0,  1'b0}, {8'd128, 8'd60, 1'b1},
    {8'd13,  8'd0,  1'b1}, {8'd128, 8'd100, 1'b1}, {8'd5,   8'd90, 1'b1},
    {8'd127, 8'd40, 1'b1}, {8'd128, 8'd30, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n, sym_valid, sym_ctrl;
  logic [7:0] sym_data;
  logic hb_we, hl_we, tr_we, pay_we, hdr_err;
  logic [HAW-1:0] hb_addr, hl_addr, tr_addr, hdr_cursor;
  logic [PAW-1:0] pay_addr, pay_cursor;
  logic [7:0] hb_data, pay_data;
  logic [15:0] hl_data;
  logic [63:0] tr_data;

  always #2.5 clk = ~clk;

  rxd_depositor #(.HAW(HAW), .PAW(PAW), .MAXH(128), .PAY_BASE(PAY_BASE)) dut (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_ctrl(sym_ctrl),
    .sym_data(sym_data), .hb_we(hb_we), .hb_addr(hb_addr), .hb_data(hb_data),
    .hl_we(hl_we), .hl_addr(hl_addr), .hl_data(hl_data), .tr_we(tr_we),
    .tr_addr(tr_addr), .tr_data(tr_data), .pay_we(pay_we), .pay_addr(pay_addr),
    .pay_data(pay_data), .hdr_cursor(hdr_cursor), .pay_cursor(pay_cursor),
    .hdr_err(hdr_err)
  );

  logic [7:0] hmem [HSZ];
  logic [7:0] pmem [PSZ];
  int nwr = 0, nerr = 0, checks = 0, fails = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (hb_we) hmem[hb_addr] <= hb_data;
    if (hl_we) begin
      hmem[hl_addr] <= hl_data[7:0];
      hmem[HAW'(hl_addr + 1)] <= hl_data[15:8];
    end
    if (tr_we) for (int j = 0; j < 8; j++) hmem[HAW'(tr_addr + j)] <= tr_data[8*j +: 8];
    if (pay_we) pmem[pay_addr] <= pay_data;
    if (hb_we || hl_we || tr_we || pay_we) nwr <= nwr + 1;
    if (hdr_err) nerr <= nerr + 1;
  end

  function automatic logic [7:0] hbv(int k, int i); return 8'(k * 37 + i * 5 + 1); endfunction
  function automatic logic [7:0] pbv(int k, int i); return 8'(k * 11 + i * 3 + 7); endfunction
  function automatic logic [7:0] rdh(int a); return hmem[a % HSZ]; endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(bit c, logic [7:0] d);
    @(negedge clk);
    sym_valid = 1'b1; sym_ctrl = c; sym_data = d;
    @(posedge clk); #1;
    sym_valid = 1'b0;
  endtask

  int eb = 0, ep = 0;
  int pl_len, pp_len, pk, pstart;
  bit pvalid = 0;

  task automatic check_prev();
    int bad, tro;
    logic [47:0] adr;
    logic [15:0] sz;
    // R3 length in front of the header
    chk({rdh(eb + 1), rdh(eb)} == 16'(pl_len), "R3 length", {rdh(eb + 1), rdh(eb)}, pl_len);
    bad = 0;
    for (int i = 0; i < pl_len; i++) if (rdh(eb + 2 + i) != hbv(pk, i)) bad++;
    // R2 header bytes (R9 when the entry crosses the ring end)
    chk(bad == 0, "R2 header bytes", bad, 0);
    tro = ((pl_len + 9) / 8) * 8;
    for (int j = 0; j < 6; j++) adr[8*j +: 8] = rdh(eb + tro + j);
    sz = {rdh(eb + tro + 7), rdh(eb + tro + 6)};
    // R4 trailer address, R10 when no payload
    chk(adr == PAY_BASE + 48'(pstart), "R4 payload address", adr, PAY_BASE + 48'(pstart));
    chk(sz == 16'(pp_len), "R4 payload size", sz, pp_len);
    bad = 0;
    for (int i = 0; i < pp_len; i++) if (pmem[(pstart + i) % PSZ] != pbv(pk, i)) bad++;
    // R5 payload bytes
    chk(bad == 0, "R5 payload bytes", bad, 0);
    eb = (eb + tro + 8) % HSZ;
    // R6 R9 header cursor
    chk(hdr_cursor == HAW'(eb), "R6 header cursor", hdr_cursor, eb);
    // R7 payload cursor
    chk(pay_cursor == PAW'(ep), "R7 payload cursor", pay_cursor, ep);
    pvalid = 0;
  endtask

  task automatic open_pkt();
    send(1'b1, NEWHDR);
    repeat (2) @(posedge clk);
    #1;
    if (pvalid) check_prev();
  endtask

  task automatic send_body(int k, int hl, int pln, bit has, bit ins);
    for (int i = 0; i < hl; i++) begin
      send(1'b0, hbv(k, i));
      if (ins && i == 1) send(1'b1, 8'h7E);
    end
    if (has) send(1'b1, PAYSYM);
    for (int i = 0; i < pln; i++) send(1'b0, pbv(k, i));
    pl_len = hl; pp_len = pln; pk = k; pstart = ep;
    ep = (ep + pln) % PSZ;
    pvalid = 1;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int hb0, pc0, e0;
    rst_n = 1'b0; sym_valid = 1'b0; sym_ctrl = 1'b0; sym_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R6 R7 reset state
    chk(hdr_cursor == '0, "R6 reset header cursor", hdr_cursor, 0);
    chk(pay_cursor == '0, "R7 reset payload cursor", pay_cursor, 0);
    chk(hdr_err == 1'b0, "R8 reset error", hdr_err, 0);
    // R1 bytes and symbols outside a packet are ignored
    send(1'b0, 8'h11); send(1'b0, 8'h22); send(1'b1, PAYSYM); send(1'b0, 8'h33);
    send(1'b1, 8'h7E);
    repeat (2) @(posedge clk); #1;
    chk(nwr == 0, "R1 idle writes", nwr, 0);
    chk(pay_cursor == '0, "R1 idle payload cursor", pay_cursor, 0);
    // table, walked twice so both rings wrap (R9)
    for (int k = 0; k < 2 * NV; k++) begin
      open_pkt();
      send_body(k, int'(VEC[k % NV][16:9]), int'(VEC[k % NV][8:1]), VEC[k % NV][0], 1'b0);
    end
    // R1 unknown control code inside a header is not counted or written
    open_pkt();
    send_body(20, 4, 0, 1'b0, 1'b1);
    open_pkt();
    // R8 over-length header
    hb0 = eb; pc0 = ep; e0 = nerr;
    for (int i = 0; i < 130; i++) send(1'b0, 8'(i));
    send(1'b1, PAYSYM);
    for (int i = 0; i < 3; i++) send(1'b0, 8'h5A);
    send(1'b1, NEWHDR);
    repeat (2) @(posedge clk); #1;
    chk(nerr - e0 == 1, "R8 error pulses", nerr - e0, 1);
    chk(hdr_cursor == HAW'(hb0), "R8 cursor held", hdr_cursor, hb0);
    ep = (pc0 + 3) % PSZ;
    chk(pay_cursor == PAW'(ep), "R8 payload kept", pay_cursor, ep);
    chk(pmem[(pc0 + 2) % PSZ] == 8'h5A, "R8 payload byte", pmem[(pc0 + 2) % PSZ], 8'h5A);
    // next packet reuses the discarded entry's base
    send_body(21, 2, 0, 1'b0, 1'b0);
    open_pkt();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule